// File: doc/BRIEF.md
# Banked Vector Register File

This block holds the vector registers of a vector unit: eight registers of 32-bit elements. Storage is split into eight banks, one per lane. Element `e` of every register sits in lane `e mod 8`, at row `e / 8` of that lane's bank. Because of this layout, one cycle can reach eight consecutive elements of a register, one in each lane. Each bank has two read ports and one write port. A single large memory with many ports would cost far more area and power.

Three clients in each lane share the bank's ports over time: the memory interface, the floating-point adder and the floating-point multiplier. In each lane, a fixed-priority arbiter picks one client for the read-port pair and one client for the write port. Any client that requests a port and does not get it sees its stall output high for that cycle and must hold its request.

A granted read fetches two operands, A and B, from the lane's bank. The data and a per-client valid flag arrive one clock later. A granted write stores its data only if the element's mask bit is 1. The number of elements per register is a parameter and may be 8, 16, 32 or 64.

Top module: `vreg_bank_file`

## Requirements
- R1: After reset every element of every register reads as zero, and no read-valid output is high.
- R2: Element e of register r is reached through lane e mod 8, using row index e / 8 and register index r. A value written there is returned by a later read of the same lane, row and register, and no other register changes.
- R3: A granted read request (req high, stall low) raises that client's read-valid output and shows the data on the lane's read outputs exactly one clock later. In the request cycle itself, read-valid is low.
- R4: A single read grant returns two independent operands, port A and port B, which may be at different rows of the same lane's bank.
- R5: If a read and a write address the same element in the same cycle, the read returns the value from before the write. The next read returns the new value.
- R6: A granted write changes the element only when its mask input is 1. With mask 0 the element keeps its old value.
- R7: Read-port arbitration in each lane follows fixed priority, client 0 (memory interface) over client 1 (adder) over client 2 (multiplier). Each requesting client that loses has its read-stall bit high, the winner's bit is low, and only the winner gets read-valid.
- R8: Write-port arbitration uses the same fixed priority. A stalled write leaves storage unchanged.
- R9: All eight lanes are independent: eight writes in one cycle, or eight reads in one cycle, all complete with no stall.
- R10: The element count N_ELEMS must be 8, 16, 32 or 64, which is checked at elaboration. It sets N_ELEMS/8 rows per bank, so the last element N_ELEMS-1 is in lane 7 at row N_ELEMS/8-1 and is fully storable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 8x3 | Read request per lane and client |
| rd_reg_a | input | 8x3x3 | Register index for operand A |
| rd_row_a | input | 8x3xROW_AW | Row (element / 8) for operand A |
| rd_reg_b | input | 8x3x3 | Register index for operand B |
| rd_row_b | input | 8x3xROW_AW | Row for operand B |
| rd_stall | output | 8x3 | Read request lost arbitration this cycle |
| rd_valid | output | 8x3 | Read data of this client is on the lane outputs |
| rd_data_a | output | 8x32 | Operand A per lane |
| rd_data_b | output | 8x32 | Operand B per lane |
| wr_req | input | 8x3 | Write request per lane and client |
| wr_reg | input | 8x3x3 | Register index of the write |
| wr_row | input | 8x3xROW_AW | Row of the write |
| wr_data | input | 8x3x32 | Write data |
| wr_mask | input | 8x3 | Element mask bit; 1 enables the store |
| wr_stall | output | 8x3 | Write request lost arbitration this cycle |

## Verification
The bench targets contention in a single lane. Three clients reading at once and two clients writing one element at once show whether the priority order is reversed or whether a loser's write leaks into storage. It also writes and reads the same element in the same cycle: a design with write-first bypass would return the new value. Masked-off writes are tested, because a design that ignores the mask would overwrite the element. The first and last elements of a register and full eight-lane bursts are used to expose a wrong lane or row mapping, which shows up as data appearing in the wrong element or register.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

   localparam int unsigned N_CLIENTS = 3;

   // Client index doubles as priority rank: lower index wins.
   typedef enum logic [1:0] {
      CL_MEM = 2'd0,
      CL_ADD = 2'd1,
      CL_MUL = 2'd2
   } client_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vrf_prio_arb.sv
module vrf_prio_arb #(
   parameter int unsigned N  = 3,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);

   generate
      if (N < 1) begin : g_bad_n
         $error("vrf_prio_arb: N must be at least 1");
      end
   endgenerate

   always_comb begin
      logic found;
      gnt   = '0;
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            idx    = IW'(i);
            found  = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
   parameter int unsigned W        = 32,
   parameter int unsigned DEPTH    = 16,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);

   logic [W-1:0] store [DEPTH];

   // Read registers sample the array before this edge's write lands.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_a <= '0;
         rdata_b <= '0;
      end else if (re) begin
         rdata_a <= store[raddr_a];
         rdata_b <= store[raddr_b];
      end
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) store[i] <= '0;
            end else if (we) begin
               store[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) store[waddr] <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/vreg_bank_file.sv
module vreg_bank_file import vrf_pkg::*; #(
   parameter int unsigned N_REGS   = 8,
   parameter int unsigned ELEM_W   = 32,
   parameter int unsigned N_LANES  = 8,
   parameter int unsigned N_ELEMS  = 16,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned NC      = N_CLIENTS,
   localparam int unsigned ROWS    = N_ELEMS / N_LANES,
   localparam int unsigned REG_AW  = (N_REGS > 1) ? $clog2(N_REGS) : 1,
   localparam int unsigned ROW_AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N_LANES-1:0][NC-1:0]             rd_req,
   input  logic [N_LANES-1:0][NC-1:0][REG_AW-1:0] rd_reg_a,
   input  logic [N_LANES-1:0][NC-1:0][ROW_AW-1:0] rd_row_a,
   input  logic [N_LANES-1:0][NC-1:0][REG_AW-1:0] rd_reg_b,
   input  logic [N_LANES-1:0][NC-1:0][ROW_AW-1:0] rd_row_b,
   output logic [N_LANES-1:0][NC-1:0]             rd_stall,
   output logic [N_LANES-1:0][NC-1:0]             rd_valid,
   output logic [N_LANES-1:0][ELEM_W-1:0]         rd_data_a,
   output logic [N_LANES-1:0][ELEM_W-1:0]         rd_data_b,
   input  logic [N_LANES-1:0][NC-1:0]             wr_req,
   input  logic [N_LANES-1:0][NC-1:0][REG_AW-1:0] wr_reg,
   input  logic [N_LANES-1:0][NC-1:0][ROW_AW-1:0] wr_row,
   input  logic [N_LANES-1:0][NC-1:0][ELEM_W-1:0] wr_data,
   input  logic [N_LANES-1:0][NC-1:0]             wr_mask,
   output logic [N_LANES-1:0][NC-1:0]             wr_stall
);

   localparam int unsigned DEPTH = N_REGS * ROWS;
   localparam int unsigned DAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CIW   = (NC > 1) ? $clog2(NC) : 1;

   // R10: element count restricted to the supported set
   generate
      if (!(N_ELEMS == 8 || N_ELEMS == 16 || N_ELEMS == 32 || N_ELEMS == 64)) begin : g_bad_elems
         $error("vreg_bank_file: N_ELEMS must be 8, 16, 32 or 64");
      end
      if (N_LANES == 0 || (N_ELEMS % N_LANES) != 0) begin : g_bad_lanes
         $error("vreg_bank_file: N_ELEMS must be a multiple of N_LANES");
      end
      if (N_REGS < 1) begin : g_bad_regs
         $error("vreg_bank_file: N_REGS must be at least 1");
      end
   endgenerate

   function automatic logic [DAW-1:0] row_addr(input logic [REG_AW-1:0] r,
                                                input logic [ROW_AW-1:0] w);
      return DAW'(DAW'(r) * DAW'(ROWS) + DAW'(w));
   endfunction

   generate
      for (genvar l = 0; l < N_LANES; l++) begin : g_lane
         logic [NC-1:0]     rgnt, wgnt, vld_q;
         logic [CIW-1:0]    ridx, widx;
         logic              rany, wany;
         logic [DAW-1:0]    ra_a, ra_b, wa;
         logic              we;

         vrf_prio_arb #(.N(NC)) i_rd_arb (
            .req (rd_req[l]),
            .gnt (rgnt),
            .idx (ridx),
            .any (rany)
         );

         vrf_prio_arb #(.N(NC)) i_wr_arb (
            .req (wr_req[l]),
            .gnt (wgnt),
            .idx (widx),
            .any (wany)
         );

         assign rd_stall[l] = rd_req[l] & ~rgnt;
         assign wr_stall[l] = wr_req[l] & ~wgnt;

         assign ra_a = row_addr(rd_reg_a[l][ridx], rd_row_a[l][ridx]);
         assign ra_b = row_addr(rd_reg_b[l][ridx], rd_row_b[l][ridx]);
         assign wa   = row_addr(wr_reg[l][widx], wr_row[l][widx]);
         assign we   = wany & wr_mask[l][widx];

         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= rgnt;
         end
         assign rd_valid[l] = vld_q;

         vrf_bank #(
            .W              (ELEM_W),
            .DEPTH          (DEPTH),
            .CLEAR_ON_RESET (CLEAR_ON_RESET)
         ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .re      (rany),
            .raddr_a (ra_a),
            .raddr_b (ra_b),
            .rdata_a (rd_data_a[l]),
            .rdata_b (rd_data_b[l]),
            .we      (we),
            .waddr   (wa),
            .wdata   (wr_data[l][widx])
         );
      end
   endgenerate

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
   parameter int unsigned N_LANES = 8,
   parameter int unsigned NC      = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_LANES-1:0][NC-1:0] rd_req,
   input logic [N_LANES-1:0][NC-1:0] rd_stall,
   input logic [N_LANES-1:0][NC-1:0] rd_valid,
   input logic [N_LANES-1:0][NC-1:0] wr_req,
   input logic [N_LANES-1:0][NC-1:0] wr_stall
);

   generate
      for (genvar l = 0; l < N_LANES; l++) begin : g_l
         a_r7_single_read_winner: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rd_req[l] & ~rd_stall[l]) <= 1);
         a_r7_top_read_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req[l][0] |-> !rd_stall[l][0]);
         a_r7_busy_read_port: assert property (@(posedge clk) disable iff (!rst_n)
            (|rd_req[l]) |-> ((rd_req[l] & ~rd_stall[l]) != '0));
         a_r8_single_write_winner: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(wr_req[l] & ~wr_stall[l]) <= 1);
         a_r8_top_write_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
            wr_req[l][0] |-> !wr_stall[l][0]);
         a_r1_valid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rd_valid[l]));
         for (genvar c = 0; c < NC; c++) begin : g_c
            a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
               (rd_req[l][c] && !rd_stall[l][c]) |=> rd_valid[l][c]);
            a_r3_no_valid_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
               !(rd_req[l][c] && !rd_stall[l][c]) |=> !rd_valid[l][c]);
            a_r7_no_stall_without_req: assert property (@(posedge clk) disable iff (!rst_n)
               !rd_req[l][c] |-> !rd_stall[l][c]);
         end
      end
   endgenerate

endmodule

bind vreg_bank_file vrf_checker #(.N_LANES(N_LANES), .NC(NC)) i_vrf_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req   (rd_req),
   .rd_stall (rd_stall),
   .rd_valid (rd_valid),
   .wr_req   (wr_req),
   .wr_stall (wr_stall)
);

// File: tb/test_vreg_bank_file.sv
`timescale 1ns/1ps
module test_vreg_bank_file;

   localparam int L    = 8;
   localparam int C    = 3;
   localparam int W    = 32;
   localparam int NR   = 8;
   localparam int NE   = 16;
   localparam int ROWS = NE / L;
   localparam int RAW  = 3;
   localparam int OAW  = (ROWS > 1) ? $clog2(ROWS) : 1;

   logic clk = 1'b0;
   logic rst_n;
   logic [L-1:0][C-1:0]          rd_req, rd_stall, rd_valid, wr_req, wr_mask, wr_stall;
   logic [L-1:0][C-1:0][RAW-1:0] rd_reg_a, rd_reg_b, wr_reg;
   logic [L-1:0][C-1:0][OAW-1:0] rd_row_a, rd_row_b, wr_row;
   logic [L-1:0][W-1:0]          rd_data_a, rd_data_b;
   logic [L-1:0][C-1:0][W-1:0]   wr_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   vreg_bank_file #(.N_REGS(NR), .ELEM_W(W), .N_LANES(L), .N_ELEMS(NE)) i_vreg_bank_file (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_reg_a(rd_reg_a), .rd_row_a(rd_row_a),
      .rd_reg_b(rd_reg_b), .rd_row_b(rd_row_b),
      .rd_stall(rd_stall), .rd_valid(rd_valid),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
      .wr_req(wr_req), .wr_reg(wr_reg), .wr_row(wr_row),
      .wr_data(wr_data), .wr_mask(wr_mask), .wr_stall(wr_stall)
   );

   function automatic logic [W-1:0] pat(input int r, input int e);
      return 32'hA500_0000 | (r << 8) | e;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      rd_req = '0; rd_reg_a = '0; rd_row_a = '0; rd_reg_b = '0; rd_row_b = '0;
      wr_req = '0; wr_reg = '0; wr_row = '0; wr_data = '0; wr_mask = '0;
   endtask

   task automatic set_rd(input int cl, input int r, input int ea, input int eb);
      rd_req[ea % L][cl]   = 1'b1;
      rd_reg_a[ea % L][cl] = RAW'(r);
      rd_row_a[ea % L][cl] = OAW'(ea / L);
      rd_reg_b[ea % L][cl] = RAW'(r);
      rd_row_b[ea % L][cl] = OAW'(eb / L);
   endtask

   task automatic set_wr(input int cl, input int r, input int e,
                         input logic [W-1:0] d, input logic m);
      wr_req[e % L][cl]  = 1'b1;
      wr_reg[e % L][cl]  = RAW'(r);
      wr_row[e % L][cl]  = OAW'(e / L);
      wr_data[e % L][cl] = d;
      wr_mask[e % L][cl] = m;
   endtask

   // All ops start and end on a falling edge.
   task automatic write_elem(input int cl, input int r, input int e,
                             input logic [W-1:0] d, input logic m);
      set_wr(cl, r, e, d, m);
      @(negedge clk);
      idle();
   endtask

   task automatic read_elem(input int r, input int e, output logic [W-1:0] d);
      set_rd(0, r, e, e);
      @(negedge clk);
      d = rd_data_a[e % L];
      idle();
   endtask

   task automatic t_reset();
      logic [W-1:0] d;
      chk("R1 rd_valid after reset", W'(rd_valid), '0);
      read_elem(0, 0, d);  chk("R1 reg0 elem0 zero", d, '0);
      read_elem(7, 15, d); chk("R1 reg7 elem15 zero", d, '0);
   endtask

   task automatic t_mapping();
      logic [W-1:0] d;
      for (int e = 0; e < NE; e++) write_elem(1, 3, e, pat(3, e), 1'b1);
      for (int e = 0; e < NE; e++) begin
         read_elem(3, e, d);
         chk($sformatf("R2 reg3 elem%0d", e), d, pat(3, e));
      end
      read_elem(2, 5, d);  chk("R2 reg2 untouched", d, '0);
      read_elem(4, 12, d); chk("R2 reg4 untouched", d, '0);
   endtask

   task automatic t_latency();
      set_rd(2, 3, 6, 6);
      #1;
      chk("R3 no valid in request cycle", W'(rd_valid[6]), '0);
      @(negedge clk);
      chk("R3 valid one cycle later", W'(rd_valid[6]), W'(3'b100));
      chk("R3 data one cycle later", rd_data_a[6], pat(3, 6));
      idle();
      @(negedge clk);
      chk("R3 valid drops", W'(rd_valid[6]), '0);
   endtask

   task automatic t_dual();
      set_rd(1, 3, 0, 8);
      @(negedge clk);
      chk("R4 port A elem0", rd_data_a[0], pat(3, 0));
      chk("R4 port B elem8", rd_data_b[0], pat(3, 8));
      idle();
   endtask

   task automatic t_rw_same();
      logic [W-1:0] d;
      set_wr(0, 3, 1, 32'h1234_5678, 1'b1);
      set_rd(1, 3, 1, 1);
      @(negedge clk);
      chk("R5 same-cycle read old", rd_data_a[1], pat(3, 1));
      idle();
      read_elem(3, 1, d);
      chk("R5 next read new", d, 32'h1234_5678);
   endtask

   task automatic t_mask();
      logic [W-1:0] d;
      write_elem(2, 3, 4, 32'hDEAD_0000, 1'b0);
      read_elem(3, 4, d); chk("R6 mask0 keeps value", d, pat(3, 4));
      write_elem(2, 3, 4, 32'hBEEF_0001, 1'b1);
      read_elem(3, 4, d); chk("R6 mask1 stores", d, 32'hBEEF_0001);
   endtask

   task automatic t_rd_arb();
      set_rd(0, 3, 2, 2);
      set_rd(1, 3, 10, 10);
      set_rd(2, 3, 3 + 8, 3 + 8);
      rd_req[3] = '0;
      rd_req[2][2] = 1'b1; rd_reg_a[2][2] = RAW'(3); rd_row_a[2][2] = OAW'(1);
      #1;
      chk("R7 three-way stall", W'(rd_stall[2]), W'(3'b110));
      @(negedge clk);
      chk("R7 mem wins valid", W'(rd_valid[2]), W'(3'b001));
      chk("R7 mem data", rd_data_a[2], pat(3, 2));
      idle();
      set_rd(1, 3, 10, 10);
      set_rd(2, 3, 2, 2);
      #1;
      chk("R7 adder beats mul", W'(rd_stall[2]), W'(3'b100));
      @(negedge clk);
      chk("R7 adder valid", W'(rd_valid[2]), W'(3'b010));
      chk("R7 adder data", rd_data_a[2], pat(3, 10));
      idle();
   endtask

   task automatic t_wr_arb();
      logic [W-1:0] d;
      set_wr(0, 4, 5, 32'h0000_AAAA, 1'b1);
      set_wr(2, 4, 5, 32'h0000_CCCC, 1'b1);
      #1;
      chk("R8 mem beats mul stall", W'(wr_stall[5]), W'(3'b100));
      @(negedge clk);
      idle();
      read_elem(4, 5, d); chk("R8 mem write lands", d, 32'h0000_AAAA);
      set_wr(1, 4, 5, 32'h0000_BBBB, 1'b1);
      set_wr(2, 4, 5, 32'h0000_CCCC, 1'b1);
      #1;
      chk("R8 adder beats mul stall", W'(wr_stall[5]), W'(3'b100));
      @(negedge clk);
      idle();
      read_elem(4, 5, d); chk("R8 stalled write no effect", d, 32'h0000_BBBB);
   endtask

   task automatic t_lanes();
      for (int e = 0; e < L; e++) set_wr(e % C, 6, e + 8, pat(6, e + 8), 1'b1);
      #1;
      chk("R9 no write stall", W'(wr_stall), '0);
      @(negedge clk);
      idle();
      for (int e = 0; e < L; e++) set_rd(2, 6, e + 8, e + 8);
      #1;
      chk("R9 no read stall", W'(rd_stall), '0);
      @(negedge clk);
      for (int e = 0; e < L; e++)
         chk($sformatf("R9 lane%0d data", e), rd_data_a[e], pat(6, e + 8));
      idle();
   endtask

   task automatic t_last();
      logic [W-1:0] d;
      write_elem(0, NR - 1, NE - 1, 32'hFFFF_0F0F, 1'b1);
      read_elem(NR - 1, NE - 1, d);
      chk("R10 last element of last reg", d, 32'hFFFF_0F0F);
      read_elem(NR - 1, NE - 1 - L, d);
      chk("R10 row below untouched", d, '0);
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mapping();
      t_latency();
      t_dual();
      t_rw_same();
      t_mask();
      t_rd_arb();
      t_wr_arb();
      t_lanes();
      t_last();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule